// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a memory ECC decoder and keeps a record of the first error it reports, so that software can read it later. The decoder signals each corrected (single-bit) or uncorrectable (multi-bit) read with a one-cycle pulse, together with the failing address and the 8-bit syndrome. The block packs this into one 32-bit status word. The word holds sticky flags, a frozen address and syndrome, two interrupt enables and a scrub-disable control.

Software reads the word through `rd_data_o` and writes it through a plain write strobe. It writes 1 to both flag bits at once to release the capture. While a flag is set and its enable is on, the matching level output (`nmi_o` for corrected errors, `serr_o` for uncorrectable ones) stays high. Every corrected read also raises a one-cycle scrub request, unless software has disabled scrubbing.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, `rd_data_o` reads 0, `nmi_o`, `serr_o` and `scrub_req_o` are 0, and scrubbing is enabled (bit 31 = 0).
- R2: A single-bit pulse (`sbe_i`=1, `mbe_i`=0) that arrives while both flags are clear sets bit 0. From the next cycle, bits 30:12 read `err_addr_i[31:13]` and bits 11:4 read `err_syn_i`, as sampled with that pulse.
- R3: A multi-bit pulse (`mbe_i`=1) that arrives while both flags are clear sets bit 1 and captures the address and syndrome in the same way as R2.
- R4: While bit 0 or bit 1 is set, error pulses of either type change neither flag, nor the address field, nor the syndrome field. Only one flag is ever set.
- R5: When `sbe_i` and `mbe_i` are both 1 in one cycle with both flags clear, only bit 1 is set, and that cycle's address and syndrome are captured.
- R6: A write clears the flags only when `wr_data_i[1:0]` = 2'b11. A write with either of these bits 0 leaves both flags and the captured fields unchanged. After a clear, the address and syndrome fields keep their last values.
- R7: An error pulse in the same cycle as a clearing write is logged as the new first error, following R2, R3 and R5.
- R8: Bits 31 (scrub disable), 3 (system-error enable) and 2 (NMI enable) are loaded from `wr_data_i` on every write and read back the written values. Writes to bits 30:4 have no effect.
- R9: `nmi_o` equals bit 0 AND bit 2. `serr_o` equals bit 1 AND bit 3. Both are levels and drop in the cycle after the flags are cleared.
- R10: `scrub_req_o` is 1 for exactly the cycle after each cycle in which `sbe_i`=1, `mbe_i`=0 and bit 31 = 0, whatever the flag state. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sbe_i | input | 1 | Corrected-error pulse from the decoder |
| mbe_i | input | 1 | Uncorrectable-error pulse from the decoder |
| err_addr_i | input | 32 | Failing address that goes with the pulse |
| err_syn_i | input | 8 | Syndrome that goes with the pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| nmi_o | output | 1 | NMI request level |
| serr_o | output | 1 | System-error request level |
| scrub_req_o | output | 1 | One-cycle scrub request |

## Verification
On every cycle, the assertions check that the flags are never both set, and that the capture stays frozen while a flag is held and no clear arrives. They also check that a simultaneous error pair logs only the multi-bit flag, that a clean clearing write empties the flags, and that the scrub request follows corrected reads according to the disable bit. Some behaviour is visible only in the bench's scenarios, which compare a behavioural model against the ports on every clock. This covers the exact packing of the address and syndrome, the rejection of half-clears, the new error captured in a clearing cycle, the write-only effect on the enables, and the interrupt levels under each combination of enables.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned SBE_BIT       = 0;
  localparam int unsigned MBE_BIT       = 1;
  localparam int unsigned NMI_EN_BIT    = 2;
  localparam int unsigned SERR_EN_BIT   = 3;
  localparam int unsigned SYN_LSB       = 4;
  localparam int unsigned SCRUB_DIS_BIT = 31;

  typedef struct packed {
    logic scrub_dis;
    logic serr_en;
    logic nmi_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic             clr_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.scrub_dis <= wr_data_i[SCRUB_DIS_BIT];
      ctrl_q.serr_en   <= wr_data_i[SERR_EN_BIT];
      ctrl_q.nmi_en    <= wr_data_i[NMI_EN_BIT];
    end
  end

  // both flag bits must be written as 1 together
  assign clr_o  = wr_en_i & wr_data_i[SBE_BIT] & wr_data_i[MBE_BIT];
  assign ctrl_o = ctrl_q;

  // R8
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q));
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned KEEP_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic              clr_i,
  output logic              sbe_flag_o,
  output logic              mbe_flag_o,
  output logic [KEEP_W-1:0] addr_o,
  output logic [SYN_W-1:0]  syn_o
);
  logic              sbe_q, mbe_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;
  logic              open_w, take_w;

  // capture window is open when no flag survives this cycle
  assign open_w = clr_i | ~(sbe_q | mbe_q);
  assign take_w = open_w & (sbe_i | mbe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
      addr_q <= '0;
      syn_q  <= '0;
    end else begin
      if (open_w) begin
        mbe_q <= mbe_i;
        sbe_q <= sbe_i & ~mbe_i;
      end
      if (take_w) begin
        addr_q <= addr_i[ADDR_W-1 -: KEEP_W];
        syn_q  <= syn_i;
      end
    end
  end

  assign sbe_flag_o = sbe_q;
  assign mbe_flag_o = mbe_q;
  assign addr_o     = addr_q;
  assign syn_o      = syn_q;

  // R4
  one_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sbe_q, mbe_q}));

  // R4
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_q | mbe_q) && !clr_i |=> $stable(addr_q) && $stable(syn_q) && $stable({sbe_q, mbe_q}));

  // R5
  mbe_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_i && mbe_i && (clr_i || !(sbe_q || mbe_q)) |=> mbe_q && !sbe_q);

  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !sbe_i && !mbe_i |=> !sbe_q && !mbe_q);

  // R2
  sbe_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_i && !mbe_i && !sbe_q && !mbe_q |=> sbe_q && syn_q == $past(syn_i));
endmodule

// File: rtl/ecc_cap_req.sv
module ecc_cap_req
  import ecc_cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sbe_i,
  input  logic  mbe_i,
  input  logic  sbe_flag_i,
  input  logic  mbe_flag_i,
  input  ctrl_t ctrl_i,
  output logic  nmi_o,
  output logic  serr_o,
  output logic  scrub_req_o
);
  logic scrub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scrub_q <= 1'b0;
    else         scrub_q <= sbe_i & ~mbe_i & ~ctrl_i.scrub_dis;
  end

  assign nmi_o       = sbe_flag_i & ctrl_i.nmi_en;
  assign serr_o      = mbe_flag_i & ctrl_i.serr_en;
  assign scrub_req_o = scrub_q;

  // R10
  scrub_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_i && !mbe_i && !ctrl_i.scrub_dis |=> scrub_req_o);

  // R10
  scrub_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.scrub_dis || mbe_i || !sbe_i |=> !scrub_req_o);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              nmi_o,
  output logic              serr_o,
  output logic              scrub_req_o
);
  localparam int unsigned ADDR_LSB = SYN_LSB + SYN_W;
  localparam int unsigned KEEP_W   = SCRUB_DIS_BIT - ADDR_LSB;

  ctrl_t             ctrl;
  logic              clr;
  logic              sbe_flag, mbe_flag;
  logic [KEEP_W-1:0] cap_addr;
  logic [SYN_W-1:0]  cap_syn;

  ecc_cap_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl),
    .clr_o    (clr)
  );

  ecc_cap_log #(
    .ADDR_W(ADDR_W),
    .SYN_W (SYN_W),
    .KEEP_W(KEEP_W)
  ) u_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sbe_i     (sbe_i),
    .mbe_i     (mbe_i),
    .addr_i    (err_addr_i),
    .syn_i     (err_syn_i),
    .clr_i     (clr),
    .sbe_flag_o(sbe_flag),
    .mbe_flag_o(mbe_flag),
    .addr_o    (cap_addr),
    .syn_o     (cap_syn)
  );

  ecc_cap_req u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sbe_i      (sbe_i),
    .mbe_i      (mbe_i),
    .sbe_flag_i (sbe_flag),
    .mbe_flag_i (mbe_flag),
    .ctrl_i     (ctrl),
    .nmi_o      (nmi_o),
    .serr_o     (serr_o),
    .scrub_req_o(scrub_req_o)
  );

  always_comb begin
    rd_data_o                            = '0;
    rd_data_o[SBE_BIT]                   = sbe_flag;
    rd_data_o[MBE_BIT]                   = mbe_flag;
    rd_data_o[NMI_EN_BIT]                = ctrl.nmi_en;
    rd_data_o[SERR_EN_BIT]               = ctrl.serr_en;
    rd_data_o[SYN_LSB +: SYN_W]          = cap_syn;
    rd_data_o[ADDR_LSB +: KEEP_W]        = cap_addr;
    rd_data_o[SCRUB_DIS_BIT]             = ctrl.scrub_dis;
  end

  // R9
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !sbe_i && !mbe_i |=> !nmi_o && !serr_o);
endmodule

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe = 1'b0, mbe = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wd = '0;
  logic [7:0]  syn = '0;
  logic [31:0] rd;
  logic        nmi, serr, scrub;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  bit        m_s, m_m, m_dis, m_ne, m_se, m_scrub;
  bit [18:0] m_addr;
  bit [7:0]  m_syn;

  always #10 clk = ~clk;

  ecc_err_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .sbe_i(sbe), .mbe_i(mbe),
    .err_addr_i(addr), .err_syn_i(syn), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .nmi_o(nmi), .serr_o(serr), .scrub_req_o(scrub)
  );

  function automatic logic [31:0] model_word();
    return {m_dis, m_addr, m_syn, m_se, m_ne, m_m, m_s};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s, m_m, m_dis, m_ne, m_se, m_scrub} = '0;
      m_addr = '0;
      m_syn  = '0;
    end else begin
      m_scrub = sbe && !mbe && !m_dis;
      if (we && wd[0] && wd[1]) begin m_s = 0; m_m = 0; end
      if (!m_s && !m_m && (sbe || mbe)) begin
        if (mbe) m_m = 1; else m_s = 1;
        m_addr = addr / 8192;
        m_syn  = syn;
      end
      if (we) begin m_dis = wd[31]; m_se = wd[3]; m_ne = wd[2]; end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    check("model rd_data", rd, model_word());
    check("model nmi", 32'(nmi), 32'(m_s & m_ne));
    check("model serr", 32'(serr), 32'(m_m & m_se));
    check("model scrub", 32'(scrub), 32'(m_scrub));
  end

  task automatic step(bit s, bit m, logic [31:0] a, logic [7:0] y, bit w, logic [31:0] d);
    sbe = s; mbe = m; addr = a; syn = y; we = w; wd = d;
    @(posedge clk);
    @(negedge clk);
    sbe = 0; mbe = 0; we = 0;
  endtask

  function automatic logic [31:0] pack(bit dis, logic [31:0] a, logic [7:0] y, bit se, bit ne, bit fm, bit fs);
    return {dis, a[31:13], y, se, ne, fm, fs};
  endfunction

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 rd_data", rd, 0);
    check("R1 irq", {nmi, serr, scrub}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd, 0);

    // R8: enables load, read-only fields ignore writes
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFC);
    check("R8 write all", rd, 32'h8000_000C);
    step(0, 0, 0, 0, 1, 32'h0000_000C);
    check("R8 enables only", rd, 32'h0000_000C);

    // R2 + R10 + R9
    step(1, 0, 32'h1234_5678, 8'hA5, 0, 0);
    check("R2 capture", rd, pack(0, 32'h1234_5678, 8'hA5, 1, 1, 0, 1));
    check("R10 scrub pulse", 32'(scrub), 1);
    check("R9 nmi level", {nmi, serr}, 2'b10);
    @(negedge clk);
    check("R10 pulse ends", 32'(scrub), 0);

    // R4
    step(0, 1, 32'hFEDC_BA98, 8'h3C, 0, 0);
    check("R4 mbe ignored", rd, pack(0, 32'h1234_5678, 8'hA5, 1, 1, 0, 1));
    step(1, 0, 32'h0F0F_0000, 8'h11, 0, 0);
    check("R4 sbe ignored", rd, pack(0, 32'h1234_5678, 8'hA5, 1, 1, 0, 1));

    // R6 half clears
    step(0, 0, 0, 0, 1, 32'h0000_000D);
    check("R6 bit0 only", rd, pack(0, 32'h1234_5678, 8'hA5, 1, 1, 0, 1));
    step(0, 0, 0, 0, 1, 32'h0000_000E);
    check("R6 bit1 only", rd, pack(0, 32'h1234_5678, 8'hA5, 1, 1, 0, 1));
    step(0, 0, 0, 0, 1, 32'h0000_000F);
    check("R6 full clear", rd, pack(0, 32'h1234_5678, 8'hA5, 1, 1, 0, 0));
    check("R9 drop", {nmi, serr}, 0);

    // R3
    step(0, 1, 32'hCAFE_E000, 8'h5A, 0, 0);
    check("R3 capture", rd, pack(0, 32'hCAFE_E000, 8'h5A, 1, 1, 1, 0));
    check("R9 serr level", {nmi, serr}, 2'b01);
    check("R10 no scrub on mbe", 32'(scrub), 0);
    step(1, 0, 32'h1111_1111, 8'h22, 0, 0);
    check("R10 scrub while held", 32'(scrub), 1);
    check("R4 held", rd, pack(0, 32'hCAFE_E000, 8'h5A, 1, 1, 1, 0));
    step(0, 0, 0, 0, 1, 32'h0000_0003);
    check("R9 serr disabled", rd, pack(0, 32'hCAFE_E000, 8'h5A, 0, 0, 0, 0));

    // R5
    step(1, 1, 32'hABCD_2000, 8'h77, 0, 0);
    check("R5 mbe wins", rd, pack(0, 32'hABCD_2000, 8'h77, 0, 0, 1, 0));
    check("R9 serr masked", {nmi, serr}, 0);
    check("R10 no scrub both", 32'(scrub), 0);

    // R7
    step(1, 0, 32'h7654_3000, 8'h99, 1, 32'h0000_0007);
    check("R7 new capture", rd, pack(0, 32'h7654_3000, 8'h99, 0, 1, 0, 1));
    check("R9 nmi", {nmi, serr}, 2'b10);

    // R10 disabled
    step(0, 0, 0, 0, 1, 32'h8000_0003);
    step(1, 0, 32'h0, 8'h1, 0, 0);
    check("R10 scrub off", 32'(scrub), 0);
    check("R2 after disable", rd, pack(1, 32'h0, 8'h1, 0, 0, 0, 1));

    // random phase against model
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0, $urandom,
           8'($urandom), $urandom_range(0, 5) == 0,
           ($urandom_range(0, 1) ? 32'h3 : 32'h0) | ($urandom & 32'hFFFF_FFFC));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule